// File: doc/BRIEF.md
# Page Write Buffer and Program Sequencer

This block sits behind the serial command decoder of a serial non-volatile memory. When the decoder recognises a page write command, it presents the start address, then one strobe for each complete data byte, and finally a pulse when chip select returns high. The block gathers the bytes into a page-sized buffer. Only the low address bits, which form the page offset, advance from byte to byte. Each slot that receives a byte is marked in a per-offset valid mask.

A command is accepted only if the write-enable latch was set when the command arrived. It goes on to programming only if chip select rises on a byte boundary after at least one data byte. Programming is a self-timed cycle of a fixed number of system clocks, with busy raised for the whole cycle. During the first page-length cycles the buffer is walked in ascending offset order. Every marked byte whose address the protection logic does not flag is written through a one-cycle write port. No erase step is needed. In the last busy cycle the block pulses a request that clears the write-enable latch.

Top module: `eeprom_page_programmer`

## Requirements
- R1: A write command that arrives while `wel_i` is 0 starts no program cycle and writes nothing. The block returns to idle on the next `cs_rise_i`.
- R2: Each data byte goes to page offset (start offset + byte index) modulo PAGE_BYTES. The address bits above the offset stay those of the start address, so no other page is touched.
- R3: If more than PAGE_BYTES bytes arrive, the offset wraps and a later byte replaces the earlier byte at the same offset. Only the last value sent to an offset is programmed.
- R4: A program cycle starts only when `cs_rise_i` arrives with `frag_i` = 0 (no partial byte pending) and at least one data byte has been received. Otherwise the command is cancelled and nothing is written.
- R5: `busy_o` rises in the cycle after an accepted `cs_rise_i` and stays high for exactly PROG_CYCLES clock cycles. PROG_CYCLES must exceed PAGE_BYTES.
- R6: A byte whose array address gives `prot_i` = 1 on the write port is not written. The stored value at that address is unchanged.
- R7: Only offsets that received a byte are written, and each is written at most once per cycle. Array addresses outside those offsets keep their contents.
- R8: `wel_clr_o` is a single-cycle pulse in the last cycle of `busy_o`, once per program cycle.
- R9: Write commands, data strobes and chip-select rises that arrive while `busy_o` is high are ignored. They neither extend the cycle nor change what is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_cmd_i | input | 1 | One-cycle pulse: page write command and address received |
| wr_addr_i | input | ADDR_W | Start byte address of the command |
| data_stb_i | input | 1 | One-cycle pulse: a complete data byte is on `data_i` |
| data_i | input | 8 | Received data byte |
| cs_rise_i | input | 1 | One-cycle pulse: chip select went high |
| frag_i | input | 1 | With `cs_rise_i`: 1 if some bits of a further byte were shifted |
| wel_i | input | 1 | Write-enable latch state |
| prot_i | input | 1 | Protection flag for the address on `mem_addr_o` |
| busy_o | output | 1 | Program cycle in progress |
| wel_clr_o | output | 1 | Pulse: clear the write-enable latch |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | 8 | Array write data |
| mem_we_o | output | 1 | Array write strobe, one byte per cycle |

## Verification
Writes are swept over every page and every start offset of a small configuration. Lengths run from a single byte to past one page, so runs that stay inside the page are told apart from those that wrap and overwrite. The protected limit is moved between full, upper three quarters, upper half and upper quarter of the array, which separates skipped bytes from written ones. A separate set of runs varies the gating conditions: latch clear, a mid-byte chip-select rise, a rise with no data, and a second command during busy. In these runs the busy length and the latch-clear pulse count show whether a cycle started, and the full array compare shows whether anything leaked into memory.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_DROP = 2'd2,
    ST_PROG = 2'd3
  } pw_state_e;
endpackage

// File: rtl/pw_prog_timer.sv
module pw_prog_timer #(
  parameter int PROG_CYCLES = 625000,
  localparam int CNT_W = $clog2(PROG_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)      cnt_d = '0;
    else if (last_o) cnt_d = '0;
    else             cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last_o = run_i && (cnt_q == CNT_W'(PROG_CYCLES - 1));
  assign cnt_o  = cnt_q;

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(PROG_CYCLES)); // R5
  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !last_o) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R5
endmodule

// File: rtl/pw_page_buffer.sv
module pw_page_buffer #(
  parameter int PAGE_BYTES = 64,
  parameter int ADDR_W     = 15,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int BASE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              byte_we_i,
  input  logic [7:0]        byte_i,
  input  logic              clr_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output logic [7:0]        rd_data_o,
  output logic              rd_valid_o,
  output logic              any_o,
  output logic [BASE_W-1:0] base_o
);
  logic [BASE_W-1:0]     base_q, base_d;
  logic [OFF_W-1:0]      off_q, off_d;
  logic [PAGE_BYTES-1:0] vld_q, vld_d;
  logic [7:0]            slot_data [PAGE_BYTES];

  always_comb begin
    base_d = base_q;
    off_d  = off_q;
    vld_d  = vld_q;
    if (load_i) begin
      base_d = load_addr_i[ADDR_W-1:OFF_W];
      off_d  = load_addr_i[OFF_W-1:0];
      vld_d  = '0;
    end else if (clr_i) begin
      vld_d  = '0;
    end else if (byte_we_i) begin
      vld_d[off_q] = 1'b1;
      off_d        = off_q + OFF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      off_q  <= '0;
      vld_q  <= '0;
    end else begin
      base_q <= base_d;
      off_q  <= off_d;
      vld_q  <= vld_d;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic [7:0] byte_q;
    logic       hit;
    assign hit = byte_we_i && !load_i && !clr_i && (off_q == OFF_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   byte_q <= '0;
      else if (hit) byte_q <= byte_i;
    end
    assign slot_data[g] = byte_q;
  end

  assign rd_data_o  = slot_data[rd_off_i];
  assign rd_valid_o = vld_q[rd_off_i];
  assign any_o      = |vld_q;
  assign base_o     = base_q;

  AST_MASK_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we_i && !load_i && !clr_i) |=> vld_q[$past(off_q)]); // R7
  AST_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(base_q)); // R2
endmodule

// File: rtl/pw_sequencer.sv
module pw_sequencer
  import pw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_cmd_i,
  input  logic wel_i,
  input  logic data_stb_i,
  input  logic cs_rise_i,
  input  logic frag_i,
  input  logic any_i,
  input  logic last_i,
  output logic load_o,
  output logic byte_we_o,
  output logic clr_o,
  output logic run_o,
  output logic wel_clr_o
);
  pw_state_e st_q, st_d;

  always_comb begin
    st_d      = st_q;
    load_o    = 1'b0;
    byte_we_o = 1'b0;
    clr_o     = 1'b0;
    wel_clr_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (wr_cmd_i) begin
          if (wel_i) begin
            st_d   = ST_FILL;
            load_o = 1'b1;
          end else begin
            st_d   = ST_DROP;
          end
        end
      end
      ST_FILL: begin
        if (cs_rise_i) begin
          if (!frag_i && any_i) begin
            st_d = ST_PROG;
          end else begin
            st_d  = ST_IDLE;
            clr_o = 1'b1;
          end
        end else if (data_stb_i) begin
          byte_we_o = 1'b1;
        end
      end
      ST_DROP: begin
        if (cs_rise_i) st_d = ST_IDLE;
      end
      ST_PROG: begin
        if (last_i) begin
          st_d      = ST_IDLE;
          clr_o     = 1'b1;
          wel_clr_o = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign run_o = (st_q == ST_PROG);

  AST_START_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_o) |-> $past(cs_rise_i && !frag_i && any_i)); // R4
  AST_DROP_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DROP) |=> !run_o); // R1
  AST_CLR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr_o |=> !run_o); // R8
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && !last_i) |=> run_o); // R9
endmodule

// File: rtl/eeprom_page_programmer.sv
module eeprom_page_programmer #(
  parameter int PAGE_BYTES  = 64,
  parameter int ADDR_W      = 15,
  parameter int PROG_CYCLES = 625000,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int BASE_W = ADDR_W - OFF_W,
  localparam int CNT_W  = $clog2(PROG_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cmd_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              data_stb_i,
  input  logic [7:0]        data_i,
  input  logic              cs_rise_i,
  input  logic              frag_i,
  input  logic              wel_i,
  input  logic              prot_i,
  output logic              busy_o,
  output logic              wel_clr_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              mem_we_o
);
  logic              rst_s1_q, rst_s2_q, rst_sn;
  logic              load, byte_we, clr, run, last;
  logic              any, rd_valid, commit;
  logic [CNT_W-1:0]  cnt;
  logic [OFF_W-1:0]  rd_off;
  logic [7:0]        rd_data;
  logic [BASE_W-1:0] base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_sn = rst_s2_q;

  pw_sequencer i_seq (
    .clk        (clk),
    .rst_n      (rst_sn),
    .wr_cmd_i   (wr_cmd_i),
    .wel_i      (wel_i),
    .data_stb_i (data_stb_i),
    .cs_rise_i  (cs_rise_i),
    .frag_i     (frag_i),
    .any_i      (any),
    .last_i     (last),
    .load_o     (load),
    .byte_we_o  (byte_we),
    .clr_o      (clr),
    .run_o      (run),
    .wel_clr_o  (wel_clr_o)
  );

  pw_page_buffer #(.PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W)) i_buf (
    .clk         (clk),
    .rst_n       (rst_sn),
    .load_i      (load),
    .load_addr_i (wr_addr_i),
    .byte_we_i   (byte_we),
    .byte_i      (data_i),
    .clr_i       (clr),
    .rd_off_i    (rd_off),
    .rd_data_o   (rd_data),
    .rd_valid_o  (rd_valid),
    .any_o       (any),
    .base_o      (base)
  );

  pw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) i_tmr (
    .clk    (clk),
    .rst_n  (rst_sn),
    .run_i  (run),
    .cnt_o  (cnt),
    .last_o (last)
  );

  assign rd_off      = cnt[OFF_W-1:0];
  assign commit      = run && (cnt < CNT_W'(PAGE_BYTES));
  assign mem_addr_o  = {base, rd_off};
  assign mem_wdata_o = rd_data;
  assign mem_we_o    = commit && rd_valid && !prot_i;
  assign busy_o      = run;

  AST_WRITE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_we_o |-> busy_o); // R7
  AST_CLR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_sn)
    wel_clr_o |-> busy_o); // R8
  AST_NO_START_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy_o && cs_rise_i && !wel_clr_o) |=> busy_o); // R9
endmodule

// File: tb/test_eeprom_page_programmer.sv
module test_eeprom_page_programmer;
  localparam int P      = 8;
  localparam int AW     = 6;
  localparam int PROG   = 40;
  localparam int DEPTH  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_cmd_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic          data_stb_i = 1'b0;
  logic [7:0]    data_i = '0;
  logic          cs_rise_i = 1'b0;
  logic          frag_i = 1'b0;
  logic          wel_i = 1'b0;
  logic          prot_i;
  logic          busy_o, wel_clr_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [7:0]    mem_wdata_o;

  int checks = 0;
  int fails = 0;
  int prot_lim = DEPTH;
  int busy_seen = 0;
  int clr_seen = 0;
  logic [7:0] mem   [DEPTH];
  logic [7:0] model [DEPTH];

  always #4 clk = ~clk;

  assign prot_i = (int'(mem_addr_o) >= prot_lim);

  eeprom_page_programmer #(.PAGE_BYTES(P), .ADDR_W(AW), .PROG_CYCLES(PROG)) i_eeprom_page_programmer (
    .clk(clk), .rst_n(rst_n), .wr_cmd_i(wr_cmd_i), .wr_addr_i(wr_addr_i),
    .data_stb_i(data_stb_i), .data_i(data_i), .cs_rise_i(cs_rise_i), .frag_i(frag_i),
    .wel_i(wel_i), .prot_i(prot_i), .busy_o(busy_o), .wel_clr_o(wel_clr_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o)
  );

  always @(posedge clk) if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;

  always @(negedge clk) begin
    if (busy_o)    busy_seen++;
    if (wel_clr_o) clr_seen++;
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a, input int i, input int s);
    return 8'((a * 7 + i * 13 + s * 29 + 3) & 8'hFF);
  endfunction

  task automatic send_cmd(input int addr, input bit wel);
    @(negedge clk); wel_i = wel; wr_cmd_i = 1'b1; wr_addr_i = AW'(addr);
    @(negedge clk); wr_cmd_i = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d);
    data_i = d; data_stb_i = 1'b1;
    @(negedge clk); data_stb_i = 1'b0;
  endtask

  task automatic send_rise(input bit frag);
    cs_rise_i = 1'b1; frag_i = frag;
    @(negedge clk); cs_rise_i = 1'b0; frag_i = 1'b0;
  endtask

  task automatic compare_mem(input string req);
    int bad = 0;
    int first = -1;
    for (int a = 0; a < DEPTH; a++)
      if (mem[a] !== model[a]) begin
        bad++;
        if (first < 0) first = a;
      end
    if (first < 0) check(1'b1, req, 0, 0);
    else check(1'b0, req, int'(mem[first]), int'(model[first]));
  endtask

  task automatic run_write(input int addr, input int n, input bit frag, input bit wel,
                           input int seed, input string req);
    bit start = wel && (n > 0) && !frag;
    int base = (addr / P) * P;
    int off = addr % P;
    busy_seen = 0; clr_seen = 0;
    send_cmd(addr, wel);
    for (int i = 0; i < n; i++) send_byte(pat(addr, i, seed));
    send_rise(frag);
    repeat (PROG + 8) @(negedge clk);
    if (start)
      for (int i = 0; i < n; i++) begin
        int a = base + ((off + i) % P);
        if (a < prot_lim) model[a] = pat(addr, i, seed);
      end
    check(busy_seen == (start ? PROG : 0), {req, " busy length R5"}, busy_seen, start ? PROG : 0);
    check(clr_seen == (start ? 1 : 0), {req, " latch clear R8"}, clr_seen, start ? 1 : 0);
    compare_mem({req, " array"});
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) begin
      mem[a] = 8'(a ^ 8'hA5);
      model[a] = 8'(a ^ 8'hA5);
    end
    repeat (3) @(negedge clk);
    check(busy_o == 1'b0 && mem_we_o == 1'b0 && wel_clr_o == 1'b0, "reset idle R5",
          int'({busy_o, mem_we_o, wel_clr_o}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy_o == 1'b0, "after reset R5", int'(busy_o), 0);

    // Sweep: every page, every start offset, lengths 1..11 (wraps when > P), moving protection
    for (int pg = 0; pg < DEPTH / P; pg++)
      for (int off = 0; off < P; off++) begin
        prot_lim = DEPTH - 16 * ((pg + off) % 4);
        run_write(pg * P + off, ((pg + off) % 11) + 1, 1'b0, 1'b1, pg + off,
                  "R2/R3/R6/R7 sweep");
      end
    prot_lim = DEPTH;

    // R1: latch clear, command ignored
    run_write(10, 4, 1'b0, 1'b0, 50, "R1 latch clear");
    // R4: mid-byte rise cancels
    run_write(20, 3, 1'b1, 1'b1, 51, "R4 mid-byte rise");
    // R4: rise with no data
    run_write(30, 0, 1'b0, 1'b1, 52, "R4 no data");
    // R4: good write after cancels still works
    run_write(33, 2, 1'b0, 1'b1, 53, "R4 aligned rise");
    // R3: exactly two full pages of data, all overwritten once
    run_write(40, 2 * P, 1'b0, 1'b1, 54, "R3 double wrap");
    // R6: whole array protected
    prot_lim = 0;
    run_write(8, 5, 1'b0, 1'b1, 55, "R6 all protected");
    prot_lim = DEPTH;

    // R9: second command while busy is ignored
    busy_seen = 0; clr_seen = 0;
    send_cmd(2, 1'b1);
    send_byte(8'h11);
    send_byte(8'h22);
    send_rise(1'b0);
    repeat (3) @(negedge clk);
    send_cmd(50, 1'b1);
    send_byte(8'h33);
    send_byte(8'h44);
    send_rise(1'b0);
    repeat (PROG + 20) @(negedge clk);
    model[2] = 8'h11; model[3] = 8'h22;
    check(busy_seen == PROG, "R9 busy not extended", busy_seen, PROG);
    check(clr_seen == 1, "R9 single latch clear R8", clr_seen, 1);
    compare_mem("R9 intrusion ignored");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule